// File: doc/BRIEF.md
# Memory-Window Serial Flash Read Buffer

This block lets a bus master read up to four serial flash devices as if they were ordinary memory. A read address inside the flash window is decoded into a device index and a byte offset within that device, using one programmable top-address per device. The devices are stacked in a fixed priority: device 0 starts at the bottom of the window, and device k begins where device k-1 ends. With the usual setting of 64 MB per device, the four devices fill a 256 MB window.

Reads are served from a single prefetch line. A read that falls inside the span currently held in the line completes in the same cycle it is presented. A read outside that span clears the line. It then asks the flash sequencer, over a request/grant and stream port, to run a configurable read sequence that refills the line from the missed word onward. The read completes as soon as the refill has finished. Addresses beyond the last device, and any read while the block is disabled, finish at once with an error and start no flash traffic. Software must clear the line after it programs or erases the flash, by raising both soft-reset controls together.

Top module: `xip_read_buffer`

## Requirements
- R1: The device index is the lowest k for which the read address (bits [WIN_W-1:0]) is below top k. The flash offset is the address minus top k-1 (minus 0 for k = 0), with its two low bits forced to zero. On a miss these appear on fetch_chip and fetch_addr.
- R2: A read at or above the last top address is answered in the same cycle with rd_ready=1 and rd_err=1, and raises no fetch_req.
- R3: A read whose device matches the line and whose word offset w satisfies start <= w < start+count, with a valid line, gets rd_ready=1, rd_err=0 in the same cycle. rd_data is that flash word.
- R4: On a miss the line becomes invalid and fetch_req rises on the next cycle. It carries fetch_seq = cfg_seq_idx, the word-aligned offset, and fetch_bytes = cfg_fill_bytes. rd_ready stays low until the refill has completed.
- R5: A refill accepts ceil(fetch_bytes/4) words from fetch_rvalid, and at least one word when the size is 0. The span held afterwards is exactly that many words from the missed word.
- R6: When ctl_rst_bus and ctl_rst_flash are both high, the line is invalidated and the refill logic returns to idle; the next read of a previously held word misses. One of them alone has no effect.
- R7: mm_busy is high from the cycle after a miss until the refill completes, and low after reset.
- R8: While cfg_disable is high, every read completes at once with rd_err=1 and starts no fetch.
- R9: fetch_req, once raised, stays high until fetch_gnt is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_disable | input | 1 | Block disable; all reads return an error |
| ctl_rst_bus | input | 1 | Bus-side soft reset control |
| ctl_rst_flash | input | 1 | Flash-side soft reset control |
| cfg_chip_top | input | NUM_CHIPS*WIN_W | Top address per device, device k in slice k |
| cfg_fill_bytes | input | SIZE_W | Refill size in bytes |
| cfg_seq_idx | input | SEQ_W | Sequence index used for refills |
| rd_req | input | 1 | Read request, held until rd_ready |
| rd_addr | input | WIN_W | Byte address within the flash window |
| rd_ready | output | 1 | Read completion |
| rd_err | output | 1 | Error response, valid with rd_ready |
| rd_data | output | DATA_W | Read data, valid with rd_ready |
| mm_busy | output | 1 | Refill in progress |
| fetch_req | output | 1 | Refill request to the sequencer |
| fetch_gnt | input | 1 | Sequencer accepts the request |
| fetch_seq | output | SEQ_W | Sequence index for the refill |
| fetch_chip | output | CHIP_W | Device to read |
| fetch_addr | output | WIN_W | Byte offset in the device |
| fetch_bytes | output | SIZE_W | Bytes to read |
| fetch_rvalid | input | 1 | Returned word valid |
| fetch_rdata | input | DATA_W | Returned word |

## Verification
The hardest case to reach is the boundary of the held span: the last held word, the first word past it, the same offset on a different device, and spans from odd or zero sizes. The vector table walks reads in an order that places the buffer on exactly those edges. It then re-sizes the line and re-programs uneven top addresses. The bench's sequencer model streams data as a function of device and word, so a wrong decode or a stale line shows up as a data mismatch, and the model counts grants to show that error paths start no fetch.

// File: rtl/xrb_pkg.sv
package xrb_pkg;
   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_REQ  = 2'd1,
      FS_FILL = 2'd2
   } fill_state_e;
endpackage

// File: rtl/xrb_decode.sv
module xrb_decode #(
   parameter int NUM_CHIPS = 4,
   parameter int WIN_W     = 29,
   localparam int CHIP_W   = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1
) (
   input  logic [WIN_W-1:0]           addr,
   input  logic [NUM_CHIPS*WIN_W-1:0] tops,
   output logic                       in_range,
   output logic [CHIP_W-1:0]          chip,
   output logic [WIN_W-1:0]           offset
);
   logic [WIN_W-1:0]     top_q  [NUM_CHIPS];
   logic [WIN_W-1:0]     base_q [NUM_CHIPS];
   logic [NUM_CHIPS-1:0] below;
   logic [WIN_W-1:0]     sel_base;

   for (genvar k = 0; k < NUM_CHIPS; k++) begin : g_chip
      assign top_q[k] = tops[k*WIN_W +: WIN_W];
      assign below[k] = addr < top_q[k];
      if (k == 0) begin : g_first
         assign base_q[k] = '0;
      end else begin : g_next
         assign base_q[k] = top_q[k-1];
      end
   end

   always_comb begin
      in_range = 1'b0;
      chip     = '0;
      sel_base = '0;
      for (int k = NUM_CHIPS - 1; k >= 0; k--) begin
         if (below[k]) begin
            in_range = 1'b1;
            chip     = CHIP_W'(k);
            sel_base = base_q[k];
         end
      end
      offset = addr - sel_base;
      offset[1:0] = 2'b00;
   end
endmodule

// File: rtl/xrb_store.sv
module xrb_store #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 6,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_data;
   end

   assign rd_data = mem[rd_idx];
endmodule

// File: rtl/xrb_fill.sv
module xrb_fill import xrb_pkg::*; #(
   parameter int CHIP_W = 2,
   parameter int WIN_W  = 29,
   parameter int SIZE_W = 8,
   parameter int SEQ_W  = 4,
   localparam int IDX_W = SIZE_W - 2,
   localparam int CNT_W = SIZE_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inv,
   input  logic              miss_go,
   input  logic [CHIP_W-1:0] req_chip,
   input  logic [WIN_W-3:0]  req_word,
   input  logic [SIZE_W-1:0] cfg_bytes,
   input  logic [SEQ_W-1:0]  cfg_seq,
   output logic              fetch_req,
   input  logic              fetch_gnt,
   output logic [SEQ_W-1:0]  fetch_seq,
   output logic [CHIP_W-1:0] fetch_chip,
   output logic [WIN_W-1:0]  fetch_addr,
   output logic [SIZE_W-1:0] fetch_bytes,
   input  logic              fetch_rvalid,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic              busy,
   output logic              valid,
   output logic [CHIP_W-1:0] tag_chip,
   output logic [WIN_W-3:0]  tag_word,
   output logic [CNT_W-1:0]  tag_cnt
);
   fill_state_e       state;
   logic [SIZE_W:0]   bytes_rnd;
   logic [CNT_W-1:0]  words;
   logic              last_word;

   assign bytes_rnd = {1'b0, cfg_bytes} + (SIZE_W+1)'(3);
   assign words     = (bytes_rnd[SIZE_W:2] == '0) ? CNT_W'(1) : bytes_rnd[SIZE_W:2];
   assign last_word = (CNT_W'(wr_idx) + CNT_W'(1)) == tag_cnt;

   assign fetch_req  = (state == FS_REQ);
   assign busy       = (state != FS_IDLE);
   assign wr_en      = (state == FS_FILL) && fetch_rvalid;
   assign fetch_chip = tag_chip;
   assign fetch_addr = {tag_word, 2'b00};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= FS_IDLE;
         valid       <= 1'b0;
         tag_chip    <= '0;
         tag_word    <= '0;
         tag_cnt     <= '0;
         wr_idx      <= '0;
         fetch_seq   <= '0;
         fetch_bytes <= '0;
      end else if (inv) begin
         state  <= FS_IDLE;
         valid  <= 1'b0;
         wr_idx <= '0;
      end else begin
         case (state)
            FS_IDLE: begin
               if (miss_go) begin
                  valid       <= 1'b0;
                  tag_chip    <= req_chip;
                  tag_word    <= req_word;
                  tag_cnt     <= words;
                  fetch_seq   <= cfg_seq;
                  fetch_bytes <= cfg_bytes;
                  wr_idx      <= '0;
                  state       <= FS_REQ;
               end
            end
            FS_REQ: begin
               if (fetch_gnt) state <= FS_FILL;
            end
            FS_FILL: begin
               if (fetch_rvalid) begin
                  if (last_word) begin
                     valid <= 1'b1;
                     state <= FS_IDLE;
                  end else begin
                     wr_idx <= wr_idx + IDX_W'(1);
                  end
               end
            end
            default: state <= FS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/xip_read_buffer.sv
module xip_read_buffer #(
   parameter int NUM_CHIPS = 4,
   parameter int WIN_W     = 29,
   parameter int SIZE_W    = 8,
   parameter int SEQ_W     = 4,
   parameter int DATA_W    = 32,
   localparam int CHIP_W   = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1,
   localparam int IDX_W    = SIZE_W - 2,
   localparam int CNT_W    = SIZE_W - 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_disable,
   input  logic                       ctl_rst_bus,
   input  logic                       ctl_rst_flash,
   input  logic [NUM_CHIPS*WIN_W-1:0] cfg_chip_top,
   input  logic [SIZE_W-1:0]          cfg_fill_bytes,
   input  logic [SEQ_W-1:0]           cfg_seq_idx,
   input  logic                       rd_req,
   input  logic [WIN_W-1:0]           rd_addr,
   output logic                       rd_ready,
   output logic                       rd_err,
   output logic [DATA_W-1:0]          rd_data,
   output logic                       mm_busy,
   output logic                       fetch_req,
   input  logic                       fetch_gnt,
   output logic [SEQ_W-1:0]           fetch_seq,
   output logic [CHIP_W-1:0]          fetch_chip,
   output logic [WIN_W-1:0]           fetch_addr,
   output logic [SIZE_W-1:0]          fetch_bytes,
   input  logic                       fetch_rvalid,
   input  logic [DATA_W-1:0]          fetch_rdata
);
   if (SIZE_W < 3) begin : g_bad_size
      $error("SIZE_W must be at least 3");
   end
   if (WIN_W < 4) begin : g_bad_win
      $error("WIN_W must be at least 4");
   end
   if (NUM_CHIPS < 1) begin : g_bad_chips
      $error("NUM_CHIPS must be at least 1");
   end

   logic              inv;
   logic              in_range;
   logic [CHIP_W-1:0] dec_chip;
   logic [WIN_W-1:0]  dec_off;
   logic [WIN_W-3:0]  off_word;
   logic [WIN_W-3:0]  span_pos;
   logic              hit;
   logic              miss_go;
   logic              line_valid;
   logic [CHIP_W-1:0] tag_chip;
   logic [WIN_W-3:0]  tag_word;
   logic [CNT_W-1:0]  tag_cnt;
   logic              wr_en;
   logic [IDX_W-1:0]  wr_idx;
   logic              bad;

   assign inv = ctl_rst_bus & ctl_rst_flash;

   xrb_decode #(.NUM_CHIPS(NUM_CHIPS), .WIN_W(WIN_W)) u_decode (
      .addr     (rd_addr),
      .tops     (cfg_chip_top),
      .in_range (in_range),
      .chip     (dec_chip),
      .offset   (dec_off)
   );

   assign off_word = dec_off[WIN_W-1:2];
   assign span_pos = off_word - tag_word;
   assign hit      = line_valid && (tag_chip == dec_chip) && (off_word >= tag_word)
                     && (span_pos < (WIN_W-2)'(tag_cnt));

   assign bad      = cfg_disable | ~in_range;
   assign rd_ready = rd_req & (bad | (hit & ~inv));
   assign rd_err   = rd_req & bad;
   assign miss_go  = rd_req & ~bad & ~hit & ~inv & ~mm_busy;

   xrb_fill #(
      .CHIP_W (CHIP_W),
      .WIN_W  (WIN_W),
      .SIZE_W (SIZE_W),
      .SEQ_W  (SEQ_W)
   ) u_fill (
      .clk          (clk),
      .rst_n        (rst_n),
      .inv          (inv),
      .miss_go      (miss_go),
      .req_chip     (dec_chip),
      .req_word     (off_word),
      .cfg_bytes    (cfg_fill_bytes),
      .cfg_seq      (cfg_seq_idx),
      .fetch_req    (fetch_req),
      .fetch_gnt    (fetch_gnt),
      .fetch_seq    (fetch_seq),
      .fetch_chip   (fetch_chip),
      .fetch_addr   (fetch_addr),
      .fetch_bytes  (fetch_bytes),
      .fetch_rvalid (fetch_rvalid),
      .wr_en        (wr_en),
      .wr_idx       (wr_idx),
      .busy         (mm_busy),
      .valid        (line_valid),
      .tag_chip     (tag_chip),
      .tag_word     (tag_word),
      .tag_cnt      (tag_cnt)
   );

   xrb_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (fetch_rdata),
      .rd_idx  (span_pos[IDX_W-1:0]),
      .rd_data (rd_data)
   );
endmodule

// File: rtl/xrb_chk.sv
module xrb_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_disable,
   input logic ctl_rst_bus,
   input logic ctl_rst_flash,
   input logic rd_req,
   input logic rd_ready,
   input logic rd_err,
   input logic mm_busy,
   input logic fetch_req,
   input logic fetch_gnt
);
   // R2
   err_nofetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ready && rd_err && !fetch_req) |=> !fetch_req);

   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !fetch_gnt && !(ctl_rst_bus && ctl_rst_flash)) |=> fetch_req);

   // R3
   hit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ready && !rd_err) |-> !mm_busy);

   // R6
   inv_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rst_bus && ctl_rst_flash) |=> (!mm_busy && !fetch_req));

   // R8
   disable_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_disable && rd_req) |-> (rd_ready && rd_err));

   // R4
   miss_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mm_busy && !cfg_disable && rd_ready) |-> rd_err);
endmodule

bind xip_read_buffer xrb_chk u_xrb_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_disable   (cfg_disable),
   .ctl_rst_bus   (ctl_rst_bus),
   .ctl_rst_flash (ctl_rst_flash),
   .rd_req        (rd_req),
   .rd_ready      (rd_ready),
   .rd_err        (rd_err),
   .mm_busy       (mm_busy),
   .fetch_req     (fetch_req),
   .fetch_gnt     (fetch_gnt)
);

// File: tb/test_xip_read_buffer.sv
module test_xip_read_buffer;
   localparam int NC = 4, WW = 29, SW = 8, QW = 4, DW = 32, CW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_disable = 1'b0, ctl_rst_bus = 1'b0, ctl_rst_flash = 1'b0;
   logic [NC*WW-1:0] cfg_chip_top;
   logic [SW-1:0] cfg_fill_bytes = 8'h80;
   logic [QW-1:0] cfg_seq_idx = 4'h2;
   logic rd_req = 1'b0;
   logic [WW-1:0] rd_addr = '0;
   logic rd_ready, rd_err, mm_busy, fetch_req;
   logic [DW-1:0] rd_data;
   logic fetch_gnt = 1'b0, fetch_rvalid = 1'b0;
   logic [DW-1:0] fetch_rdata = '0;
   logic [QW-1:0] fetch_seq;
   logic [CW-1:0] fetch_chip;
   logic [WW-1:0] fetch_addr;
   logic [SW-1:0] fetch_bytes;

   int tests = 0, fails = 0, grants = 0;
   logic [QW-1:0] last_seq;
   logic [WW-1:0] last_addr;
   logic [SW-1:0] last_bytes;
   logic [CW-1:0] last_chip;
   int last_words;

   always #10 clk = ~clk;

   xip_read_buffer i_xip_read_buffer (.*);

   function automatic logic [31:0] fw(input logic [1:0] chip, input logic [26:0] word);
      return {4'hA, 2'b00, chip, word[23:0]};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // sequencer model: grant, then stream words derived from device and word
   initial begin
      forever begin
         @(negedge clk);
         if (fetch_req && rst_n) begin
            fetch_gnt  = 1'b1;
            grants++;
            last_seq   = fetch_seq;
            last_addr  = fetch_addr;
            last_bytes = fetch_bytes;
            last_chip  = fetch_chip;
            last_words = (fetch_bytes == 0) ? 1 : (int'(fetch_bytes) + 3) / 4;
            @(negedge clk);
            fetch_gnt = 1'b0;
            for (int i = 0; i < last_words; i++) begin
               fetch_rvalid = 1'b1;
               fetch_rdata  = fw(last_chip, 27'(last_addr[WW-1:2]) + 27'(i));
               @(negedge clk);
            end
            fetch_rvalid = 1'b0;
         end
      end
   end

   task automatic do_read(input logic [WW-1:0] a, output logic [31:0] d,
                          output logic e, output int waits, output logic busy_seen);
      @(negedge clk);
      rd_req = 1'b1;
      rd_addr = a;
      waits = 0;
      busy_seen = 1'b0;
      #1;
      while (!rd_ready && waits < 1000) begin
         @(negedge clk);
         #1;
         waits++;
         if (mm_busy) busy_seen = 1'b1;
      end
      d = rd_data;
      e = rd_err;
      rd_req = 1'b0;
   endtask

   task automatic set_tops(input logic [WW-1:0] t0, t1, t2, t3);
      cfg_chip_top = {t3, t2, t1, t0};
   endtask

   task automatic pulse_ctl(input logic a, input logic b);
      @(negedge clk);
      ctl_rst_bus = a;
      ctl_rst_flash = b;
      repeat (3) @(negedge clk);
      ctl_rst_bus = 1'b0;
      ctl_rst_flash = 1'b0;
   endtask

   // [30]=expect hit, [29]=expect error, [28:0]=address (uniform 64 MB devices)
   localparam logic [30:0] VEC [11] = '{
      {1'b0, 1'b0, 29'h0000_0100},
      {1'b1, 1'b0, 29'h0000_0104},
      {1'b1, 1'b0, 29'h0000_017C},
      {1'b0, 1'b0, 29'h0000_0180},
      {1'b0, 1'b0, 29'h0000_0100},
      {1'b0, 1'b0, 29'h0400_0100},
      {1'b1, 1'b0, 29'h0400_0110},
      {1'b0, 1'b0, 29'h0C00_0000},
      {1'b0, 1'b1, 29'h1000_0000},
      {1'b0, 1'b0, 29'h0FFF_FFFC},
      {1'b0, 1'b0, 29'h0C00_0004}
   };

   initial begin
      logic [31:0] d;
      logic e, bs;
      int w, g0;
      set_tops(29'h0400_0000, 29'h0800_0000, 29'h0C00_0000, 29'h1000_0000);
      repeat (3) @(negedge clk);
      // R7 reset state
      check("R7 reset busy", 32'(mm_busy), 0);
      check("R7 reset fetch_req", 32'(fetch_req), 0);
      check("R7 reset ready", 32'(rd_ready), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int v = 0; v < 11; v++) begin
         logic [WW-1:0] a;
         a = VEC[v][28:0];
         g0 = grants;
         do_read(a, d, e, w, bs);
         check("R2 err flag", 32'(e), 32'(VEC[v][29]));
         if (VEC[v][29]) begin
            check("R2 no fetch", 32'(grants - g0), 0);
            check("R2 same cycle", 32'(w), 0);
         end else begin
            check("R1 data", d, fw(a[27:26], 27'(a[25:2])));
            if (VEC[v][30]) check("R3 hit zero wait", 32'(w), 0);
            else begin
               check("R4 miss waits", 32'(w > 0), 1);
               check("R7 busy in miss", 32'(bs), 1);
            end
         end
      end

      // R4 sequence index, aligned offset, size carried
      cfg_seq_idx = 4'h9;
      do_read(29'h0400_0106, d, e, w, bs);
      check("R4 seq", 32'(last_seq), 9);
      check("R4 addr", 32'(last_addr), 32'h104);
      check("R1 chip", 32'(last_chip), 1);
      check("R4 bytes", 32'(last_bytes), 32'h80);
      check("R4 data", d, fw(2'd1, 27'h41));

      // R5 sizes
      cfg_fill_bytes = 8'd8;
      do_read(29'h3000, d, e, w, bs);
      check("R5 words 8B", 32'(last_words), 2);
      do_read(29'h3004, d, e, w, bs);
      check("R5 hit in 8B", 32'(w), 0);
      check("R5 data", d, fw(2'd0, 27'hC01));
      do_read(29'h3008, d, e, w, bs);
      check("R5 past 8B misses", 32'(w > 0), 1);
      cfg_fill_bytes = 8'd0;
      do_read(29'h4000, d, e, w, bs);
      check("R5 zero size one word", 32'(last_words), 1);
      do_read(29'h4000, d, e, w, bs);
      check("R5 zero size hit", 32'(w), 0);
      do_read(29'h4004, d, e, w, bs);
      check("R5 zero size next misses", 32'(w > 0), 1);
      cfg_fill_bytes = 8'd5;
      do_read(29'h5000, d, e, w, bs);
      do_read(29'h5004, d, e, w, bs);
      check("R5 5B rounds up", 32'(w), 0);
      do_read(29'h5008, d, e, w, bs);
      check("R5 5B third misses", 32'(w > 0), 1);
      cfg_fill_bytes = 8'h80;

      // R6 invalidation
      do_read(29'h2000, d, e, w, bs);
      pulse_ctl(1'b1, 1'b0);
      do_read(29'h2004, d, e, w, bs);
      check("R6 single bit keeps line", 32'(w), 0);
      pulse_ctl(1'b0, 1'b1);
      do_read(29'h2008, d, e, w, bs);
      check("R6 other bit keeps line", 32'(w), 0);
      pulse_ctl(1'b1, 1'b1);
      do_read(29'h2004, d, e, w, bs);
      check("R6 both bits invalidate", 32'(w > 0), 1);
      check("R6 refetched data", d, fw(2'd0, 27'h801));

      // R8 disable
      cfg_disable = 1'b1;
      g0 = grants;
      do_read(29'h2008, d, e, w, bs);
      check("R8 err on held word", 32'(e), 1);
      do_read(29'h7000, d, e, w, bs);
      check("R8 err on miss", 32'(e), 1);
      check("R8 no fetch", 32'(grants - g0), 0);
      cfg_disable = 1'b0;
      do_read(29'h2008, d, e, w, bs);
      check("R8 line kept", 32'(w), 0);

      // R1/R2 uneven tops
      set_tops(29'h0000_1000, 29'h0000_3000, 29'h0000_3800, 29'h0800_0000);
      do_read(29'h0FFC, d, e, w, bs);
      check("R1 below top0", d, fw(2'd0, 27'h3FF));
      do_read(29'h1000, d, e, w, bs);
      check("R1 at top0 goes dev1", d, fw(2'd1, 27'h0));
      do_read(29'h3804, d, e, w, bs);
      check("R1 dev3 offset", d, fw(2'd3, 27'h1));
      g0 = grants;
      do_read(29'h0800_0000, d, e, w, bs);
      check("R2 at last top", 32'(e), 1);
      check("R2 no fetch uneven", 32'(grants - g0), 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule